// File: doc/BRIEF.md
# Power-Fail Memory Enable Controller

This block supervises the chip enable of an external static RAM and the write permission of on-chip registers while the main supply fails and returns. Three comparator flags arrive asynchronously: supply below the power-fail threshold, supply below the backup-cell voltage, and backup cell below the threshold. Each flag passes through a synchronizer before any logic uses it. While the supply is healthy, the RAM enable input passes straight to the enable output. On a failure the output is blocked. A RAM access that is already under way may finish, but only within a bounded number of cycles. After recovery the enable stays blocked for a long hold-off.

The block also selects between the main supply and the backup cell. One of two switching rules is chosen by a parameter. A battery-isolation latch keeps the backup path disconnected from the moment the cell is attached until the supply first comes up valid. A synchronous reset represents the battery attach event. All time limits are parameters counted in clock cycles.

Top module: `pfc_ce_ctrl`

## Requirements
- R1: While the controller is in its valid state, `ce_n_o` equals `ce_n_i` in the same cycle.
- R2: When the synchronized power-fail flag rises while `ce_n_i` is high (no access), the controller enters its protected state on the next clock edge and holds `ce_n_o` high (inactive) whatever `ce_n_i` does.
- R3: When the synchronized power-fail flag rises while `ce_n_i` is low, `ce_n_o` stays low for as long as `ce_n_i` stays low. The edge after `ce_n_i` goes high moves the controller to the protected state.
- R4: An access still running after `WPT_CYCLES` cycles in the fail-wait state is cut off: `ce_n_o` goes high even while `ce_n_i` stays low.
- R5: After the synchronized power-fail flag falls, `ce_n_o` stays high for exactly `CER_CYCLES` cycles in the recovery state, independent of `ce_n_i`. After that the controller returns to the valid state.
- R6: `reg_wp_o` is high in every cycle where the synchronized power-fail flag is high. It stays high for `CSR_CYCLES` further cycles after the flag falls. It is also high for `CSR_CYCLES` cycles after reset.
- R7: With `SRC_RULE` = 0, `src_backup_o` is high exactly when the synchronized supply-below-cell flag is high and the isolation latch is clear.
- R8: With `SRC_RULE` = 1, `src_backup_o` is high when the isolation latch is clear and either (a) the supply is below threshold and the cell is not below threshold, or (b) the supply is below the cell voltage and the cell is below threshold.
- R9: `cell_isolated_o` is set by reset. It clears at the first edge where the synchronized power-fail flag is low, and it never sets again until the next reset.
- R10: A new power-fail during fail-wait or recovery sends the controller back to the protected state. The next recovery hold-off then starts again from zero.
- R11: During and right after reset, `ce_n_o` is high, `reg_wp_o` is high and `cell_isolated_o` is high. Each comparator flag takes effect only after `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high; models battery attach |
| vcc_below_pf_i | input | 1 | Asynchronous flag: supply below power-fail threshold |
| vcc_below_cell_i | input | 1 | Asynchronous flag: supply below backup-cell voltage |
| cell_below_pf_i | input | 1 | Asynchronous flag: backup cell below power-fail threshold |
| ce_n_i | input | 1 | Active-low RAM enable from the host |
| ce_n_o | output | 1 | Active-low RAM enable to the external memory |
| reg_wp_o | output | 1 | Register write-protect, high blocks writes |
| src_backup_o | output | 1 | High selects the backup cell as the supply source |
| cell_isolated_o | output | 1 | High while the backup cell is still isolated |

## Verification
The assertions check four things on every cycle: pass-through in the valid state, the forced-high output in the protected and recovery states, the length bounds of the fail-wait and recovery windows, and the coverage of the synchronized fail flag by the write-protect. They also check that the isolation latch never sets again and that no backup selection happens while the cell is isolated. Some behaviour only the bench scenarios can show. This includes the exact cycle on which a power-fail edge reaches the outputs through the synchronizer, and the cut-off of a long access. It also includes the restart of the hold-off when the supply fails again, and the source choice across all flag combinations under both switching rules. A behavioural reference model in the bench predicts every output on every clock.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [1:0] {
      ST_VALID     = 2'd0,
      ST_FAIL_WAIT = 2'd1,
      ST_PROTECTED = 2'd2,
      ST_RECOVERY  = 2'd3
   } pfc_state_e;

   localparam int RULE_CELL   = 0;
   localparam int RULE_THRESH = 1;

   localparam int FLAG_W   = 3;
   localparam int FLAG_PF  = 0;
   localparam int FLAG_BC  = 1;
   localparam int FLAG_CL  = 2;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pfc_holdoff.sv
module pfc_holdoff #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= CW'(LIMIT);
      else if (trig)           cnt_q <= CW'(LIMIT);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   assign active = trig || (cnt_q != '0);
endmodule

// File: rtl/pfc_src_sel.sv
module pfc_src_sel #(
   parameter int RULE = 0
) (
   input  logic s_pf,
   input  logic s_bc,
   input  logic s_cl,
   input  logic isolated,
   output logic backup
);
   logic want;

   generate
      if (RULE == pfc_pkg::RULE_CELL) begin : g_cell
         assign want = s_bc;
      end else begin : g_thresh
         assign want = (s_pf && !s_cl) || (s_bc && s_cl);
      end
   endgenerate

   assign backup = want && !isolated;
endmodule

// File: rtl/pfc_fsm.sv
module pfc_fsm
   import pfc_pkg::*;
#(
   parameter int WPT_CYCLES = 4,
   parameter int CER_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       s_pf,
   input  logic       ce_n_i,
   output pfc_state_e state_o,
   output logic       ce_n_o
);
   localparam int MAXC  = (WPT_CYCLES > CER_CYCLES) ? WPT_CYCLES : CER_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);

   pfc_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + CNT_W'(1);
      unique case (state_q)
         ST_VALID: begin
            cnt_d = '0;
            if (s_pf) state_d = ce_n_i ? ST_PROTECTED : ST_FAIL_WAIT;
         end
         ST_FAIL_WAIT: begin
            if (!s_pf) begin
               state_d = ST_RECOVERY;
               cnt_d   = '0;
            end else if (ce_n_i || cnt_q == CNT_W'(WPT_CYCLES - 1)) begin
               state_d = ST_PROTECTED;
               cnt_d   = '0;
            end
         end
         ST_PROTECTED: begin
            cnt_d = '0;
            if (!s_pf) state_d = ST_RECOVERY;
         end
         ST_RECOVERY: begin
            if (s_pf) begin
               state_d = ST_PROTECTED;
               cnt_d   = '0;
            end else if (cnt_q == CNT_W'(CER_CYCLES - 1)) begin
               state_d = ST_VALID;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = ST_PROTECTED;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_PROTECTED;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o = state_q;
   assign ce_n_o  = (state_q == ST_VALID || state_q == ST_FAIL_WAIT) ? ce_n_i : 1'b1;
endmodule

// File: rtl/pfc_ce_ctrl.sv
module pfc_ce_ctrl
   import pfc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WPT_CYCLES  = 3000,
   parameter int CER_CYCLES  = 20000000,
   parameter int CSR_CYCLES  = 20000000,
   parameter int SRC_RULE    = RULE_THRESH
) (
   input  logic clk,
   input  logic rst,
   input  logic vcc_below_pf_i,
   input  logic vcc_below_cell_i,
   input  logic cell_below_pf_i,
   input  logic ce_n_i,
   output logic ce_n_o,
   output logic reg_wp_o,
   output logic src_backup_o,
   output logic cell_isolated_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WPT_CYCLES < 1 || CER_CYCLES < 1 || CSR_CYCLES < 1) begin : g_bad_lim
         $error("timer limits must be at least 1");
      end
      if (SRC_RULE != RULE_CELL && SRC_RULE != RULE_THRESH) begin : g_bad_rule
         $error("SRC_RULE must select one of the two switching rules");
      end
   endgenerate

   localparam logic [FLAG_W-1:0] FLAG_RST = 3'b011;

   logic [FLAG_W-1:0] flags_a, flags_s;
   logic              s_pf, s_bc, s_cl;
   pfc_state_e        state;
   logic              iso_q;

   assign flags_a = {cell_below_pf_i, vcc_below_cell_i, vcc_below_pf_i};

   pfc_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_RST)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (flags_a),
      .q   (flags_s)
   );

   assign s_pf = flags_s[FLAG_PF];
   assign s_bc = flags_s[FLAG_BC];
   assign s_cl = flags_s[FLAG_CL];

   pfc_fsm #(.WPT_CYCLES(WPT_CYCLES), .CER_CYCLES(CER_CYCLES)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .s_pf    (s_pf),
      .ce_n_i  (ce_n_i),
      .state_o (state),
      .ce_n_o  (ce_n_o)
   );

   pfc_holdoff #(.LIMIT(CSR_CYCLES)) u_wp (
      .clk    (clk),
      .rst    (rst),
      .trig   (s_pf),
      .active (reg_wp_o)
   );

   always_ff @(posedge clk) begin
      if (rst) iso_q <= 1'b1;
      else     iso_q <= iso_q && s_pf;
   end

   assign cell_isolated_o = iso_q;

   pfc_src_sel #(.RULE(SRC_RULE)) u_src (
      .s_pf     (s_pf),
      .s_bc     (s_bc),
      .s_cl     (s_cl),
      .isolated (iso_q),
      .backup   (src_backup_o)
   );
endmodule

// File: rtl/pfc_ce_ctrl_chk.sv
module pfc_ce_ctrl_chk
   import pfc_pkg::*;
#(
   parameter int WPT_CYCLES = 4,
   parameter int CER_CYCLES = 16
) (
   input logic       clk,
   input logic       rst,
   input pfc_state_e state,
   input logic       s_pf,
   input logic       ce_n_i,
   input logic       ce_n_o,
   input logic       reg_wp_o,
   input logic       src_backup_o,
   input logic       cell_isolated_o
);
   int fw_len;
   int rec_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         fw_len  <= 0;
         rec_len <= 0;
      end else begin
         fw_len  <= (state == ST_FAIL_WAIT) ? fw_len + 1 : 0;
         rec_len <= (state == ST_RECOVERY) ? rec_len + 1 : 0;
      end
   end

   assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
      state == ST_VALID |-> ce_n_o == ce_n_i);

   assert_blocked_R2: assert property (@(posedge clk) disable iff (rst)
      state == ST_PROTECTED |-> ce_n_o);

   assert_finish_access_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FAIL_WAIT && !ce_n_i) |-> !ce_n_o);

   assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
      state == ST_FAIL_WAIT |-> fw_len < WPT_CYCLES);

   assert_hold_blocked_R5: assert property (@(posedge clk) disable iff (rst)
      state == ST_RECOVERY |-> (ce_n_o && rec_len < CER_CYCLES));

   assert_hold_length_R5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_VALID && $past(state) == ST_RECOVERY) |-> rec_len == CER_CYCLES);

   assert_wp_cover_R6: assert property (@(posedge clk) disable iff (rst)
      s_pf |-> reg_wp_o);

   assert_no_backup_isolated_R7: assert property (@(posedge clk) disable iff (rst)
      cell_isolated_o |-> !src_backup_o);

   assert_iso_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      !cell_isolated_o |=> !cell_isolated_o);

   assert_refail_R10: assert property (@(posedge clk) disable iff (rst)
      (s_pf && state == ST_RECOVERY) |=> state == ST_PROTECTED);
endmodule

bind pfc_ce_ctrl pfc_ce_ctrl_chk #(
   .WPT_CYCLES (WPT_CYCLES),
   .CER_CYCLES (CER_CYCLES)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .state           (state),
   .s_pf            (s_pf),
   .ce_n_i          (ce_n_i),
   .ce_n_o          (ce_n_o),
   .reg_wp_o        (reg_wp_o),
   .src_backup_o    (src_backup_o),
   .cell_isolated_o (cell_isolated_o)
);

// File: tb/tb_pfc_ce_ctrl.sv
module tb_pfc_ce_ctrl;
   localparam int CLK_P = 10;
   localparam int WPT = 5;
   localparam int CER = 12;
   localparam int CSR = 7;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic rst = 1'b1;
   logic pf_i = 1'b1, bc_i = 1'b1, cl_i = 1'b0, ce_i = 1'b1;
   logic ce_o, wp_o, src_o, iso_o;
   logic ce_o_c, wp_o_c, src_o_c, iso_o_c;

   pfc_ce_ctrl #(.SYNC_STAGES(2), .WPT_CYCLES(WPT), .CER_CYCLES(CER),
                 .CSR_CYCLES(CSR), .SRC_RULE(1)) dut (
      .clk(clk), .rst(rst), .vcc_below_pf_i(pf_i), .vcc_below_cell_i(bc_i),
      .cell_below_pf_i(cl_i), .ce_n_i(ce_i), .ce_n_o(ce_o), .reg_wp_o(wp_o),
      .src_backup_o(src_o), .cell_isolated_o(iso_o));

   pfc_ce_ctrl #(.SYNC_STAGES(2), .WPT_CYCLES(WPT), .CER_CYCLES(CER),
                 .CSR_CYCLES(CSR), .SRC_RULE(0)) dut_cell (
      .clk(clk), .rst(rst), .vcc_below_pf_i(pf_i), .vcc_below_cell_i(bc_i),
      .cell_below_pf_i(cl_i), .ce_n_i(ce_i), .ce_n_o(ce_o_c), .reg_wp_o(wp_o_c),
      .src_backup_o(src_o_c), .cell_isolated_o(iso_o_c));

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   task automatic chk(string tag, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // reference model: 0 valid, 1 fail-wait, 2 protected, 3 recovery
   int m_st, m_cnt, m_wpc;
   bit m_iso;
   bit pf1, pf2, bc1, bc2, cl1, cl2;

   always @(posedge clk) begin
      bit sp;
      sp = pf2;
      if (rst) begin
         m_st = 2; m_cnt = 0; m_wpc = CSR; m_iso = 1;
         pf1 = 1; pf2 = 1; bc1 = 1; bc2 = 1; cl1 = 0; cl2 = 0;
      end else begin
         case (m_st)
            0: if (sp) begin m_st = (ce_i == 1'b1) ? 2 : 1; m_cnt = 0; end
            1: if (!sp) begin m_st = 3; m_cnt = 0; end
               else if (ce_i == 1'b1 || m_cnt == WPT - 1) begin m_st = 2; m_cnt = 0; end
               else m_cnt++;
            2: if (!sp) begin m_st = 3; m_cnt = 0; end
            default: if (sp) begin m_st = 2; m_cnt = 0; end
               else if (m_cnt == CER - 1) begin m_st = 0; m_cnt = 0; end
               else m_cnt++;
         endcase
         if (sp) m_wpc = CSR;
         else if (m_wpc > 0) m_wpc--;
         m_iso = m_iso && sp;
         pf2 = pf1; pf1 = pf_i;
         bc2 = bc1; bc1 = bc_i;
         cl2 = cl1; cl1 = cl_i;
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         logic e_ce, e_wp, e_thr, e_cell;
         string tag;
         e_ce  = (m_st == 0 || m_st == 1) ? ce_i : 1'b1;
         e_wp  = pf2 || (m_wpc != 0);
         e_thr = ((pf2 && !cl2) || (bc2 && cl2)) && !m_iso;
         e_cell = bc2 && !m_iso;
         case (m_st)
            0: tag = "R1";
            1: tag = "R3";
            2: tag = "R2";
            default: tag = "R5";
         endcase
         chk(tag, "ce_n_o", ce_o, e_ce);
         chk("R6", "reg_wp_o", wp_o, e_wp);
         chk("R8", "src_backup_o thresh rule", src_o, e_thr);
         chk("R7", "src_backup_o cell rule", src_o_c, e_cell);
         chk("R9", "cell_isolated_o", iso_o, m_iso);
         chk("R9", "cell_isolated_o cell rule", iso_o_c, m_iso);
      end
   end

   task automatic drive(logic pf, logic bc, logic cl, logic ce, int n);
      @(negedge clk);
      #1;
      pf_i = pf; bc_i = bc; cl_i = cl; ce_i = ce;
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1; rst = 1'b0;
      // R11: state right after reset
      @(negedge clk);
      chk("R11", "ce_n_o after reset", ce_o, 1'b1);
      chk("R11", "reg_wp_o after reset", wp_o, 1'b1);
      chk("R11", "cell_isolated_o after reset", iso_o, 1'b1);
      // supply comes up; hold-off and isolation release (R5, R9)
      drive(0, 0, 0, 1, 1);
      @(negedge clk);
      chk("R11", "ce_n_o one edge after supply good", ce_o, 1'b1);
      drive(0, 0, 0, 0, 4);
      chk("R5", "ce_n_o held during hold-off", ce_o, 1'b1);
      repeat (CER + 4) @(posedge clk);
      // R1 pass-through patterns
      for (int i = 0; i < 8; i++) drive(0, i[0], i[1], i[2], 1);
      drive(0, 0, 0, 0, 2);
      @(negedge clk); chk("R1", "ce_n_o follows low", ce_o, 1'b0);
      drive(0, 0, 0, 1, 2);
      @(negedge clk); chk("R1", "ce_n_o follows high", ce_o, 1'b1);
      // R2: fail without access, then toggle input and sweep source flags (R7, R8)
      drive(1, 0, 0, 1, 5);
      for (int i = 0; i < 8; i++) drive(1, i[0], i[1], i[2], 3);
      drive(1, 0, 0, 0, 3);
      @(negedge clk); chk("R2", "ce_n_o blocked during fail", ce_o, 1'b1);
      // recover and sweep source flags with supply good
      for (int i = 0; i < 4; i++) drive(0, i[0], i[1], 1, 3);
      repeat (CER + 6) @(posedge clk);
      // R3: access in progress completes
      drive(0, 0, 0, 0, 2);
      drive(1, 0, 0, 0, 4);
      @(negedge clk); chk("R3", "ce_n_o held during ongoing access", ce_o, 1'b0);
      drive(1, 0, 0, 1, 2);
      drive(1, 0, 0, 0, 2);
      @(negedge clk); chk("R3", "ce_n_o blocked after access ended", ce_o, 1'b1);
      drive(0, 0, 0, 1, CER + 6);
      // R4: long access cut off
      drive(0, 0, 0, 0, 2);
      drive(1, 1, 0, 0, WPT + 8);
      @(negedge clk); chk("R4", "ce_n_o after timeout", ce_o, 1'b1);
      // R10: refail during hold-off restarts it
      drive(0, 0, 0, 0, 6);
      drive(1, 0, 0, 0, 4);
      @(negedge clk); chk("R10", "ce_n_o on refail", ce_o, 1'b1);
      drive(0, 0, 0, 0, 8);
      @(negedge clk); chk("R10", "ce_n_o hold-off restarted", ce_o, 1'b1);
      repeat (CER + 4) @(posedge clk);
      @(negedge clk); chk("R5", "ce_n_o after hold-off", ce_o, 1'b0);
      // R9: isolation stays clear through another failure
      drive(1, 1, 1, 1, 6);
      @(negedge clk); chk("R9", "isolation stays clear", iso_o, 1'b0);
      drive(0, 0, 0, 1, CER + 6);
      // R11: reset re-isolates
      @(negedge clk); #1; rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); #1; rst = 1'b0;
      @(negedge clk);
      chk("R11", "cell_isolated_o after second reset", iso_o, 1'b1);
      chk("R11", "reg_wp_o after second reset", wp_o, 1'b1);
      repeat (CER + 6) @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule